// File: doc/BRIEF.md
# Debug-Driven Flash and Watchdog Command Sequencer

This block turns a 40-bit control word, written by an external debug agent, into single-cycle commands. A 0-to-1 change on a command bit starts one operation. Three bits drive a flash byte port (read, byte write, sector erase), taking the address and the write byte from the upper fields of the same word. Two bits drive a remote-update port: one requests a read of every status register, and one requests reconfiguration. Results come back on done strobes, and the block keeps them in probe registers that the debug agent can read back.

The block also sends a one-cycle kick to the configuration watchdog at a fixed interval. While the kick-disable bit is held at 1, no kicks are sent, so the watchdog expires and the device falls back to its factory image. The same block is placed in both the factory image and the application images. A parameter tells it which one it is in, and the reconfiguration bit has an effect only in an application image.

Top module: `dbg_seq`

## Requirements
- R1: When ctl[0] rises, ru_read_all is high for exactly one cycle, in the cycle after the clock edge that first samples the bit at 1.
- R2: When ctl[1] rises, ru_reconfig pulses for one cycle with the same timing as R1. This happens only when IS_APP=1; with IS_APP=0, ru_reconfig stays at 0.
- R3: wd_kick is a one-cycle pulse sent every KICK_PERIOD cycles. No kick is sent while ctl[2] is 1.
- R4: A rise on ctl[4], ctl[5] or ctl[6] gives a one-cycle pulse on fl_rd, fl_wr or fl_erase respectively, with R1 timing. At that pulse, fl_addr holds the value of ctl[31:8] and fl_wdata holds the value of ctl[39:32]. Both hold their values until the next command is issued.
- R5: Only one flash command is outstanding at a time. A command stays outstanding from its issue until the first fl_done. Rises on bits 4 to 6 that arrive while a command is outstanding are dropped. If several of these bits rise in the same cycle, only one command is issued, with read ahead of write and write ahead of erase, and the other rises are dropped.
- R6: drop_cnt resets to 0 and grows by the number of rises dropped in each cycle. It saturates at its all-ones value.
- R7: rd_q takes fl_rdata on the fl_done that ends a read; write and erase completions leave it unchanged. st_q takes ru_status on ru_done. Neither register changes at any other time.
- R8: Bits 3 and 7 are ignored. A command bit held at 1 for many cycles issues its command only once.
- R9: While rst_n is low, every command output, wd_kick, drop_cnt, rd_q and st_q are 0. A command bit that is already 1 when reset is released issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl | input | 40 | Debug control word |
| fl_rd | output | 1 | Flash read command pulse |
| fl_wr | output | 1 | Flash byte write command pulse |
| fl_erase | output | 1 | Flash sector erase command pulse |
| fl_addr | output | 24 | Flash address latched at issue |
| fl_wdata | output | 8 | Flash write byte latched at issue |
| fl_done | input | 1 | Flash operation complete strobe |
| fl_rdata | input | 8 | Flash read byte, valid with fl_done |
| ru_read_all | output | 1 | Request to read all remote-update status |
| ru_reconfig | output | 1 | Reconfiguration request pulse |
| ru_done | input | 1 | Remote-update read complete strobe |
| ru_status | input | STAT_W | Remote-update status, valid with ru_done |
| wd_kick | output | 1 | Watchdog reset pulse |
| rd_q | output | 8 | Captured flash read byte |
| st_q | output | STAT_W | Captured remote-update status |
| drop_cnt | output | CNT_W | Dropped-command count |

## Verification
Each command pulse is due in the cycle after the clock edge that first samples the rising bit. The bench drives ctl on the falling edge, pushes the expected command into a queue, and the monitor compares each pulse it sees at the following falling edge against the head of the queue. rd_q and st_q change on the edge that samples a done strobe, so they are checked several cycles after the bench models raise done. Kicks are counted over a window of 4*KICK_PERIOD cycles and the gap between kicks is measured, so the result does not depend on the phase of the kick counter. Watchdog checks start two cycles after ctl[2] changes, which allows for the single registered stage between that bit and wd_kick.

// File: rtl/dbg_seq.sv
module dbg_seq #(
  parameter bit IS_APP      = 1'b1,
  parameter int KICK_PERIOD = 64,
  parameter int CNT_W       = 8,
  parameter int STAT_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [39:0]       ctl,
  output logic              fl_rd,
  output logic              fl_wr,
  output logic              fl_erase,
  output logic [23:0]       fl_addr,
  output logic [7:0]        fl_wdata,
  input  logic              fl_done,
  input  logic [7:0]        fl_rdata,
  output logic              ru_read_all,
  output logic              ru_reconfig,
  input  logic              ru_done,
  input  logic [STAT_W-1:0] ru_status,
  output logic              wd_kick,
  output logic [7:0]        rd_q,
  output logic [STAT_W-1:0] st_q,
  output logic [CNT_W-1:0]  drop_cnt
);
  localparam int KW = (KICK_PERIOD > 2) ? $clog2(KICK_PERIOD) : 1;

  logic [4:0] trig, prev, rise;
  logic       pend, pend_rd;
  logic [KW-1:0] kc;

  assign trig = {ctl[6], ctl[5], ctl[4], ctl[1], ctl[0]};
  assign rise = trig & ~prev;

  wire [2:0]       req   = rise[4:2];
  wire [1:0]       nreq  = 2'(req[0]) + 2'(req[1]) + 2'(req[2]);
  wire             take  = !pend && (|req);
  wire [1:0]       ndrop = take ? nreq - 2'd1 : nreq;
  wire [CNT_W:0]   dsum  = {1'b0, drop_cnt} + (CNT_W+1)'(ndrop);
  wire             kwrap = (kc == KW'(KICK_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev        <= trig;
      pend        <= 1'b0;
      pend_rd     <= 1'b0;
      fl_rd       <= 1'b0;
      fl_wr       <= 1'b0;
      fl_erase    <= 1'b0;
      fl_addr     <= '0;
      fl_wdata    <= '0;
      ru_read_all <= 1'b0;
      ru_reconfig <= 1'b0;
      wd_kick     <= 1'b0;
      kc          <= '0;
      rd_q        <= '0;
      st_q        <= '0;
      drop_cnt    <= '0;
    end else begin
      prev        <= trig;
      ru_read_all <= rise[0];
      ru_reconfig <= IS_APP & rise[1];
      fl_rd       <= take & req[0];
      fl_wr       <= take & ~req[0] & req[1];
      fl_erase    <= take & ~req[0] & ~req[1] & req[2];
      if (take) begin
        pend     <= 1'b1;
        pend_rd  <= req[0];
        fl_addr  <= ctl[31:8];
        fl_wdata <= ctl[39:32];
      end else if (fl_done) begin
        pend <= 1'b0;
      end
      if (fl_done && pend && pend_rd) rd_q <= fl_rdata;
      if (ru_done) st_q <= ru_status;
      drop_cnt <= dsum[CNT_W] ? '1 : dsum[CNT_W-1:0];
      kc       <= kwrap ? '0 : kc + 1'b1;
      wd_kick  <= kwrap & ~ctl[2];
    end
  end
endmodule

module dbg_seq_chk #(
  parameter int CNT_W  = 8,
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fl_rd,
  input logic              fl_wr,
  input logic              fl_erase,
  input logic [23:0]       fl_addr,
  input logic              fl_done,
  input logic              ru_read_all,
  input logic              ru_reconfig,
  input logic              ru_done,
  input logic              wd_kick,
  input logic [7:0]        rd_q,
  input logic [STAT_W-1:0] st_q,
  input logic [CNT_W-1:0]  drop_cnt
);
  wire cmd = fl_rd | fl_wr | fl_erase;

  a_r5_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_rd, fl_wr, fl_erase}));
  a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    cmd |=> !cmd);
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd |=> $stable(fl_addr));
  a_r3_kick_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wd_kick |=> !wd_kick);
  a_r1_read_all_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ru_read_all |=> !ru_read_all);
  a_r2_reconfig_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ru_reconfig |=> !ru_reconfig);
  a_r6_drop_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
    drop_cnt >= $past(drop_cnt));
  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_done |=> $stable(rd_q));
  a_r7_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ru_done |=> $stable(st_q));
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !(cmd | ru_read_all | ru_reconfig | wd_kick) && drop_cnt == '0);
endmodule

bind dbg_seq dbg_seq_chk #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_chk (.*);

// File: tb/dbg_seq_test.sv
module dbg_seq_test;
  localparam int KP = 16;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [39:0] ctl = '0;
  logic fl_rd, fl_wr, fl_erase, ru_read_all, ru_reconfig, wd_kick;
  logic [23:0] fl_addr;
  logic [7:0]  fl_wdata, rd_q;
  logic [31:0] st_q;
  logic [CW-1:0] drop_cnt;
  logic fl_done = 1'b0, ru_done = 1'b0;
  logic [7:0]  fl_rdata = '0;
  logic [31:0] ru_status = '0;

  logic f_rd, f_wr, f_er, f_ra, f_rc, f_kick;
  logic [23:0] f_addr;
  logic [7:0]  f_wd, f_rdq;
  logic [31:0] f_st;
  logic [CW-1:0] f_drop;

  always #4 clk = ~clk;

  dbg_seq #(.IS_APP(1'b1), .KICK_PERIOD(KP), .CNT_W(CW)) uut (
    .clk, .rst_n, .ctl, .fl_rd, .fl_wr, .fl_erase, .fl_addr, .fl_wdata,
    .fl_done, .fl_rdata, .ru_read_all, .ru_reconfig, .ru_done, .ru_status,
    .wd_kick, .rd_q, .st_q, .drop_cnt);

  dbg_seq #(.IS_APP(1'b0), .KICK_PERIOD(KP), .CNT_W(CW)) uut_fac (
    .clk, .rst_n, .ctl, .fl_rd(f_rd), .fl_wr(f_wr), .fl_erase(f_er),
    .fl_addr(f_addr), .fl_wdata(f_wd), .fl_done, .fl_rdata,
    .ru_read_all(f_ra), .ru_reconfig(f_rc), .ru_done, .ru_status,
    .wd_kick(f_kick), .rd_q(f_rdq), .st_q(f_st), .drop_cnt(f_drop));

  int total = 0, bad = 0;
  logic [35:0] expq[$];
  string       tagq[$];
  int cyc = 0, kcnt = 0, last_k = 0, last_gap = 0, npulse = 0, frc = 0;
  int ft = 0, rt = 0, nstat = 0;
  logic [23:0] last_addr = '0;
  int exp_drop = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [3:0] kind, input logic [23:0] a, input logic [7:0] d, input string tag);
    expq.push_back({kind, a, d});
    tagq.push_back(tag);
  endtask

  // pulse a command bit for one cycle with a given address/data field
  task automatic op(input int b, input logic [23:0] a, input logic [7:0] d);
    ctl[39:32] = d;
    ctl[31:8]  = a;
    ctl[b]     = 1'b1;
    tick(1);
    ctl[b] = 1'b0;
    tick(1);
  endtask

  // flash and remote-update responders
  always @(negedge clk) begin
    if (!rst_n) begin
      fl_done = 1'b0; ru_done = 1'b0; ft = 0; rt = 0;
    end else begin
      fl_done = 1'b0;
      ru_done = 1'b0;
      if (ft != 0) begin
        ft--;
        if (ft == 0) begin fl_done = 1'b1; fl_rdata = last_addr[7:0] ^ 8'h5A; end
      end
      if (fl_rd | fl_wr | fl_erase) begin ft = 3; last_addr = fl_addr; end
      if (rt != 0) begin
        rt--;
        if (rt == 0) begin ru_done = 1'b1; nstat++; ru_status = 32'h5EED_0000 + nstat; end
      end
      if (ru_read_all) rt = 2;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      logic [35:0] got, exp;
      string tag;
      cyc++;
      if (wd_kick) begin
        if (last_k > 0) last_gap = cyc - last_k;
        last_k = cyc;
        kcnt++;
      end
      if (f_rc) frc++;
      if (fl_rd | fl_wr | fl_erase | ru_read_all | ru_reconfig) begin
        npulse++;
        got[35:32] = fl_rd ? 4'd1 : fl_wr ? 4'd2 : fl_erase ? 4'd3 : ru_read_all ? 4'd4 : 4'd5;
        got[31:8]  = (fl_rd | fl_wr | fl_erase) ? fl_addr : 24'h0;
        got[7:0]   = fl_wr ? fl_wdata : 8'h0;
        if (expq.size() == 0) begin
          chk(1'b0, "R8 unexpected command", got, 0);
        end else begin
          exp = expq.pop_front();
          tag = tagq.pop_front();
          chk(got == exp, tag, got, exp);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p0, k0;
    // R9: bit 4 high across reset
    ctl[31:8] = 24'h00ABCD;
    ctl[4] = 1'b1;
    tick(4);
    chk({fl_rd, fl_wr, fl_erase, ru_read_all, ru_reconfig, wd_kick} == 6'b0, "R9 outputs in reset",
        {fl_rd, fl_wr, fl_erase, ru_read_all, ru_reconfig, wd_kick}, 0);
    chk(drop_cnt == 0 && rd_q == 0 && st_q == 0, "R9 probes in reset", {drop_cnt, rd_q, st_q}, 0);
    rst_n = 1'b1;
    tick(6);
    chk(npulse == 0, "R9 no command from held bit", npulse, 0);
    chk(drop_cnt == 0, "R9 drop count", drop_cnt, 0);
    ctl = '0;
    tick(2);

    // R4 and R7: read, write, erase
    push(4'd1, 24'h12_3456, 8'h00, "R4 read");
    op(4, 24'h12_3456, 8'h77);
    tick(8);
    chk(rd_q == (8'h56 ^ 8'h5A), "R7 read capture", rd_q, 8'h56 ^ 8'h5A);
    push(4'd2, 24'h00_0F10, 8'hC3, "R4 write");
    op(5, 24'h00_0F10, 8'hC3);
    tick(8);
    chk(rd_q == (8'h56 ^ 8'h5A), "R7 hold after write", rd_q, 8'h56 ^ 8'h5A);
    push(4'd3, 24'h78_0000, 8'h00, "R4 erase");
    op(6, 24'h78_0000, 8'h11);
    tick(8);
    chk(rd_q == (8'h56 ^ 8'h5A), "R7 hold after erase", rd_q, 8'h56 ^ 8'h5A);

    // R1: read-all and status capture
    push(4'd4, 24'h0, 8'h0, "R1 read all");
    op(0, 24'h0, 8'h0);
    tick(6);
    chk(st_q == 32'h5EED_0001, "R7 status capture", st_q, 32'h5EED_0001);

    // R2: reconfig on application instance
    push(4'd5, 24'h0, 8'h0, "R2 reconfig");
    op(1, 24'h0, 8'h0);
    tick(4);
    chk(st_q == 32'h5EED_0001, "R7 status hold", st_q, 32'h5EED_0001);

    // R5/R6: rise while busy is dropped
    push(4'd1, 24'h00_0100, 8'h00, "R5 read before busy drop");
    op(4, 24'h00_0100, 8'h00);
    op(5, 24'h00_0200, 8'h99);
    exp_drop = 1;
    chk(drop_cnt == CW'(exp_drop), "R6 busy drop count", drop_cnt, exp_drop);
    chk(fl_addr == 24'h00_0100, "R4 address held past dropped rise", fl_addr, 24'h00_0100);
    tick(8);

    // R5: simultaneous rises, priority read > write > erase
    push(4'd1, 24'h00_0300, 8'h00, "R5 read wins over erase");
    ctl[31:8] = 24'h00_0300; ctl[4] = 1'b1; ctl[6] = 1'b1;
    tick(1); ctl = '0; tick(1);
    exp_drop = 2;
    chk(drop_cnt == CW'(exp_drop), "R6 same-cycle drop", drop_cnt, exp_drop);
    tick(8);
    push(4'd2, 24'h00_0400, 8'h3C, "R5 write wins over erase");
    ctl[39:32] = 8'h3C; ctl[31:8] = 24'h00_0400; ctl[5] = 1'b1; ctl[6] = 1'b1;
    tick(1); ctl = '0; tick(1);
    exp_drop = 3;
    chk(drop_cnt == CW'(exp_drop), "R6 write/erase drop", drop_cnt, exp_drop);
    tick(8);

    // R8: level hold issues once; reserved bits ignored
    push(4'd3, 24'h00_0500, 8'h00, "R8 held erase issues once");
    p0 = npulse;
    ctl[31:8] = 24'h00_0500; ctl[6] = 1'b1;
    tick(12);
    ctl = '0;
    tick(2);
    chk(npulse == p0 + 1, "R8 single command for held bit", npulse, p0 + 1);
    p0 = npulse;
    for (int i = 0; i < 4; i++) begin
      ctl[3] = 1'b1; ctl[7] = 1'b1; tick(1);
      ctl[3] = 1'b0; ctl[7] = 1'b0; tick(1);
    end
    tick(3);
    chk(npulse == p0, "R8 reserved bits ignored", npulse, p0);
    chk(drop_cnt == CW'(exp_drop), "R8 reserved bits no drop", drop_cnt, exp_drop);

    // R6: saturation
    for (int i = 0; i < 3; i++) begin
      push(4'd1, 24'h00_0600, 8'h00, "R6 read during saturation run");
      ctl[31:8] = 24'h00_0600; ctl[4] = 1'b1; ctl[5] = 1'b1; ctl[6] = 1'b1;
      tick(1); ctl = '0; tick(8);
      exp_drop = (exp_drop + 2 > 7) ? 7 : exp_drop + 2;
    end
    chk(drop_cnt == CW'(exp_drop), "R6 saturated count", drop_cnt, exp_drop);

    // R3: kick period and suppression
    k0 = kcnt;
    tick(4 * KP);
    chk(kcnt - k0 == 4, "R3 kicks per window", kcnt - k0, 4);
    chk(last_gap == KP, "R3 kick spacing", last_gap, KP);
    ctl[2] = 1'b1;
    tick(2);
    k0 = kcnt;
    tick(4 * KP);
    chk(kcnt == k0, "R3 kicks suppressed", kcnt - k0, 0);
    ctl[2] = 1'b0;
    tick(2 * KP + 2);
    chk(kcnt - k0 >= 2, "R3 kicks resume", kcnt - k0, 2);

    // R2: factory instance never reconfigures
    chk(frc == 0, "R2 factory reconfig ignored", frc, 0);
    chk(expq.size() == 0, "R4 all expected commands seen", expq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule